// File: doc/BRIEF.md
# DDR Bank Timing Tracker

This block sits beside the command scheduler of a DDR memory controller and follows the command stream that is actually sent to a four-bank device. For each bank it records whether a row is open, which row that is, and how long ago the bank was activated, read, written or closed. From this it presents, every cycle, which bank may accept an activate, a column access (read or write) or a precharge on the next clock edge. It also has one flag that says whether a precharge of every bank is legal.

A column access with address bit 10 set asks for auto-precharge. The tracker then closes the bank by itself at the first edge where an explicit precharge would have been legal. That edge is the end of the burst window, and it is pushed later if the minimum active time has not yet run out. Any command that breaks a tracked rule is dropped: no state changes. A one-cycle error pulse reports it.

Top module: `ddr_bank_tracker`

## Requirements
- R1: A read or write to a bank is legal only at an edge at least T_RCD cycles after that bank's activate; `rdwr_ok[b]` shows this and is low for a closed bank.
- R2: An activate is legal only to a closed bank, at least T_RC cycles after its previous activate and at least T_RP cycles after it was closed; a legal activate opens the bank and stores `cmd_row` as its open row.
- R3: Any two activates, to the same or different banks, are at least T_RRD edges apart; `act_ok` includes this shared limit.
- R4: An explicit precharge of an open bank is legal only at least T_RAS cycles after its activate.
- R5: A precharge with `cmd_a10` = 1 closes every open bank and is legal only when `pre_ok` is high for all four banks (`pre_all_ok`); a precharge to a bank that is already closed is legal and has no effect.
- R6: After a read, an explicit precharge of that bank is legal no earlier than B cycles after the read. This is the edge that lies CAS latency cycles before the last data, so the CAS latency cancels out. B is half the programmed burst length, taken from `burst_code` at the read: 1 gives 1, 2 gives 2, 3 gives 4, and 0 (reserved) gives 1.
- R7: After a write, an explicit precharge of that bank is legal no earlier than B + T_WR cycles after the write.
- R8: A read with `cmd_a10` = 1 closes the bank internally at the edge F cycles after the read, where F is the larger of B and the cycles still left to satisfy T_RAS. The bank may be activated again T_RP cycles after that edge, subject also to T_RC.
- R9: A write with `cmd_a10` = 1 closes the bank in the same way, using B + T_WR in place of B.
- R10: While an auto-precharge is pending on a bank, reads, writes and precharges to that bank are illegal. Any illegal command is ignored and raises `protocol_error` for exactly the cycle after the edge where it was presented. Opcodes 0 (no operation) and 5 to 7 are ignored without an error.
- R11: After reset all banks are closed, every `act_ok` bit and `pre_all_ok` are high, and `protocol_error` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | ROW_W | Row for an activate |
| cmd_a10 | input | 1 | Auto-precharge on read/write; all banks on precharge |
| burst_code | input | 2 | Programmed burst length code (1:2, 2:4, 3:8 beats) |
| bank_open | output | NUM_BANKS | Bank holds an open row |
| open_rows | output | NUM_BANKS*ROW_W | Open row of each bank, bank 0 in the low bits |
| act_ok | output | NUM_BANKS | Activate legal at the next edge |
| rdwr_ok | output | NUM_BANKS | Read or write legal at the next edge |
| pre_ok | output | NUM_BANKS | Single-bank precharge legal at the next edge |
| pre_all_ok | output | 1 | Precharge of all banks legal at the next edge |
| protocol_error | output | 1 | Previous edge presented an illegal command |

## Verification
On every cycle, the assertions check the following. A legal activate opens its bank and blocks a second activate, and it blocks column accesses and precharges for one cycle. Any activate blocks every activate on the next cycle. A bank that has just closed cannot be reactivated on the next cycle. An auto-precharge request removes the column and precharge permissions, and an error pulse always follows a real command. The exact cycle counts can only be shown by the bench's sweeps over every burst code for reads and writes, with and without auto-precharge. These counts are when each permission rises, and when an auto-precharge bank closes: at the end of the burst or later because of T_RAS. The sweeps also show that an illegal command leaves the open rows untouched.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    localparam logic [2:0] OP_NONE = 3'd0;
    localparam logic [2:0] OP_ACT  = 3'd1;
    localparam logic [2:0] OP_RD   = 3'd2;
    localparam logic [2:0] OP_WR   = 3'd3;
    localparam logic [2:0] OP_PRE  = 3'd4;

    // Per-bank request derived from one accepted command
    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic ap;
    } bank_req_t;

    // Clock cycles occupied by one burst (half the beats)
    function automatic int unsigned burst_cycles(input logic [1:0] code);
        case (code)
            2'd2:    return 2;
            2'd3:    return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/dbt_cnt.sv
module dbt_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/dbt_bank.sv
module dbt_bank
    import dbt_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int CW    = 6,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9,
    parameter int T_WR  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_req_t        req,
    input  logic [ROW_W-1:0] row_in,
    input  logic [CW-1:0]    bcyc,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q,
    output logic             act_ok,
    output logic             rdwr_ok,
    output logic             pre_ok
);
    logic open_q, ap_pend;
    logic rcd_z, ras_z, rc_z, rp_z, bst_z;
    logic ap_fire, close_now, col_req;
    logic [CW-1:0] bst_val;

    assign col_req   = req.rd | req.wr;
    assign bst_val   = req.rd ? (bcyc - 1'b1) : (bcyc + CW'(T_WR) - 1'b1);
    assign ap_fire   = open_q & ap_pend & ras_z & bst_z;
    assign close_now = ap_fire | (req.pre & open_q);

    dbt_cnt #(.W(CW)) u_rcd (.clk(clk), .rst(rst), .load(req.act), .val(CW'(T_RCD - 1)), .zero(rcd_z));
    dbt_cnt #(.W(CW)) u_ras (.clk(clk), .rst(rst), .load(req.act), .val(CW'(T_RAS - 1)), .zero(ras_z));
    dbt_cnt #(.W(CW)) u_rc  (.clk(clk), .rst(rst), .load(req.act), .val(CW'(T_RC - 1)),  .zero(rc_z));
    dbt_cnt #(.W(CW)) u_rp  (.clk(clk), .rst(rst), .load(close_now), .val(CW'(T_RP - 1)), .zero(rp_z));
    dbt_cnt #(.W(CW)) u_bst (.clk(clk), .rst(rst), .load(col_req), .val(bst_val),        .zero(bst_z));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            ap_pend <= 1'b0;
            row_q   <= '0;
        end else begin
            if (req.act) begin
                open_q <= 1'b1;
                row_q  <= row_in;
            end else if (close_now) begin
                open_q  <= 1'b0;
                ap_pend <= 1'b0;
            end
            if (col_req && req.ap)
                ap_pend <= 1'b1;
        end
    end

    assign is_open = open_q;
    assign act_ok  = ~open_q & rp_z & rc_z;
    assign rdwr_ok = open_q & rcd_z & ~ap_pend;
    assign pre_ok  = ~open_q | (ras_z & bst_z & ~ap_pend);

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        req.act |=> is_open && !act_ok); // R2
    AST_AP_BLOCKS_BANK: assert property (@(posedge clk) disable iff (rst)
        (col_req && req.ap) |=> !rdwr_ok && !pre_ok); // R10

    generate
        if (T_RCD > 1) begin : g_rcd_chk
            AST_RCD_GAP: assert property (@(posedge clk) disable iff (rst)
                req.act |=> !rdwr_ok); // R1
        end
        if (T_RAS > 1) begin : g_ras_chk
            AST_RAS_GAP: assert property (@(posedge clk) disable iff (rst)
                req.act |=> !pre_ok); // R4
        end
        if (T_RP > 1) begin : g_rp_chk
            AST_RP_GAP: assert property (@(posedge clk) disable iff (rst)
                $fell(is_open) |-> !act_ok); // R8
        end
    endgenerate
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import dbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 cmd_op,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic                       cmd_a10,
    input  logic [1:0]                 burst_code,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic [NUM_BANKS-1:0]       act_ok,
    output logic [NUM_BANKS-1:0]       rdwr_ok,
    output logic [NUM_BANKS-1:0]       pre_ok,
    output logic                       pre_all_ok,
    output logic                       protocol_error
);
    localparam int MAXT = T_RC + T_RAS + T_RP + T_RRD + T_RCD + T_WR + 8;
    localparam int CW   = $clog2(MAXT + 1);

    logic [NUM_BANKS-1:0] bank_act_ok;
    logic [NUM_BANKS-1:0] sel;
    logic                 rrd_z, is_cmd, legal, accept;
    logic [CW-1:0]        bcyc;

    assign bcyc = CW'(burst_cycles(burst_code));
    assign sel  = NUM_BANKS'(1) << cmd_bank;

    always_comb begin
        is_cmd = 1'b1;
        legal  = 1'b1;
        case (cmd_op)
            OP_ACT:        legal = bank_act_ok[cmd_bank] & rrd_z;
            OP_RD, OP_WR:  legal = rdwr_ok[cmd_bank];
            OP_PRE:        legal = cmd_a10 ? pre_all_ok : pre_ok[cmd_bank];
            default:       is_cmd = 1'b0;
        endcase
    end
    assign accept = is_cmd & legal;

    dbt_cnt #(.W(CW)) u_rrd (
        .clk(clk), .rst(rst),
        .load(accept && cmd_op == OP_ACT),
        .val(CW'(T_RRD - 1)),
        .zero(rrd_z)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            bank_req_t req;
            assign req.act = accept && cmd_op == OP_ACT && sel[b];
            assign req.rd  = accept && cmd_op == OP_RD  && sel[b];
            assign req.wr  = accept && cmd_op == OP_WR  && sel[b];
            assign req.pre = accept && cmd_op == OP_PRE && (cmd_a10 || sel[b]);
            assign req.ap  = cmd_a10;

            dbt_bank #(
                .ROW_W(ROW_W), .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS),
                .T_RP(T_RP), .T_RC(T_RC), .T_WR(T_WR)
            ) u_bank (
                .clk(clk), .rst(rst), .req(req), .row_in(cmd_row), .bcyc(bcyc),
                .is_open(bank_open[b]),
                .row_q(open_rows[b*ROW_W +: ROW_W]),
                .act_ok(bank_act_ok[b]),
                .rdwr_ok(rdwr_ok[b]),
                .pre_ok(pre_ok[b])
            );
        end
    endgenerate

    assign act_ok     = rrd_z ? bank_act_ok : '0;
    assign pre_all_ok = &pre_ok;

    always_ff @(posedge clk) begin
        if (rst) protocol_error <= 1'b0;
        else     protocol_error <= is_cmd & ~legal;
    end

    AST_ERR_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
        protocol_error |-> ($past(cmd_op) != OP_NONE)); // R10

    generate
        if (T_RRD > 1) begin : g_rrd_chk
            AST_RRD_GAP: assert property (@(posedge clk) disable iff (rst)
                (accept && cmd_op == OP_ACT) |=> (act_ok == '0)); // R3
        end
    endgenerate
endmodule

// File: tb/test_ddr_bank_tracker.sv
`timescale 1ns/1ps
module test_ddr_bank_tracker;
    localparam int NB = 4, ROW_W = 12;
    localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RC = 9, T_RRD = 2, T_WR = 2;
    localparam logic [2:0] NONE = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

    logic clk = 1'b0, rst = 1'b1;
    logic [2:0] cmd_op = NONE;
    logic [1:0] cmd_bank = '0;
    logic [ROW_W-1:0] cmd_row = '0;
    logic cmd_a10 = 1'b0;
    logic [1:0] burst_code = 2'd2;
    logic [NB-1:0] bank_open, act_ok, rdwr_ok, pre_ok;
    logic [NB*ROW_W-1:0] open_rows;
    logic pre_all_ok, protocol_error;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ddr_bank_tracker #(
        .NUM_BANKS(NB), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
        .T_RP(T_RP), .T_RC(T_RC), .T_RRD(T_RRD), .T_WR(T_WR)
    ) i_ddr_bank_tracker (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_a10(cmd_a10), .burst_code(burst_code), .bank_open(bank_open),
        .open_rows(open_rows), .act_ok(act_ok), .rdwr_ok(rdwr_ok), .pre_ok(pre_ok),
        .pre_all_ok(pre_all_ok), .protocol_error(protocol_error)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [2:0] op, input int bank, input int row, input bit a10);
        cmd_op = op; cmd_bank = 2'(bank); cmd_row = ROW_W'(row); cmd_a10 = a10;
        step();
        cmd_op = NONE; cmd_a10 = 1'b0;
    endtask

    function automatic int bcyc(input int code);
        return (code == 3) ? 4 : (code == 2) ? 2 : 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        chk("watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R11 reset state
        chk("R11 bank_open", int'(bank_open), 0);
        chk("R11 act_ok", int'(act_ok), 15);
        chk("R11 pre_all_ok", int'(pre_all_ok), 1);
        chk("R11 protocol_error", int'(protocol_error), 0);

        // R1 R4 R2: sweep cycles after an activate
        issue(ACT, 0, 'h5A5, 0);
        for (int k = 1; k <= T_RAS; k++) begin
            chk("R1 rdwr_ok after act", int'(rdwr_ok[0]), int'(k >= T_RCD));
            chk("R4 pre_ok after act", int'(pre_ok[0]), int'(k >= T_RAS));
            chk("R2 act_ok open bank", int'(act_ok[0]), 0);
            if (k < T_RAS) step();
        end
        chk("R2 open row", int'(open_rows[0 +: ROW_W]), 'h5A5);
        issue(PRE, 0, 0, 0);
        chk("R4 precharge accepted", int'(protocol_error), 0);
        for (int j = 1; j <= T_RC; j++) begin
            chk("R2 act_ok after pre", int'(act_ok[0]), int'(j >= T_RP && T_RAS + j >= T_RC));
            chk("R2 closed", int'(bank_open[0]), 0);
            step();
        end

        // R3 shared activate spacing
        issue(ACT, 1, 1, 0);
        for (int k = 1; k <= T_RRD; k++) begin
            chk("R3 act_ok other bank", int'(act_ok[2]), int'(k >= T_RRD));
            if (k < T_RRD) step();
        end
        issue(ACT, 2, 2, 0);
        chk("R3 second act accepted", int'(bank_open[2]), 1);
        chk("R5 pre_all blocked", int'(pre_all_ok), 0);

        // R10 illegal commands are ignored and flagged
        issue(ACT, 3, 3, 0);
        chk("R10 act inside tRRD flagged", int'(protocol_error), 1);
        chk("R10 act inside tRRD ignored", int'(bank_open[3]), 0);
        step();
        chk("R10 error one cycle", int'(protocol_error), 0);
        issue(ACT, 1, 'hFFF, 0);
        chk("R10 act to open bank flagged", int'(protocol_error), 1);
        chk("R10 open row unchanged", int'(open_rows[ROW_W +: ROW_W]), 1);
        issue(RD, 3, 0, 0);
        chk("R10 read to closed bank flagged", int'(protocol_error), 1);
        issue(PRE, 0, 0, 1);
        chk("R10 early pre-all flagged", int'(protocol_error), 1);
        chk("R10 early pre-all ignored", int'(bank_open), 6);
        issue(3'd6, 0, 0, 0);
        chk("R10 unused opcode silent", int'(protocol_error), 0);

        // R5 precharge all, and precharge of a closed bank
        repeat (T_RAS) step();
        chk("R5 pre_all_ok", int'(pre_all_ok), 1);
        issue(PRE, 0, 0, 1);
        chk("R5 all closed", int'(bank_open), 0);
        chk("R5 pre-all legal", int'(protocol_error), 0);
        issue(PRE, 3, 0, 0);
        chk("R5 pre closed bank legal", int'(protocol_error), 0);
        chk("R5 pre closed bank no effect", int'(bank_open), 0);
        repeat (T_RC + 2) step();

        // R6 R7 earliest explicit precharge after a column access
        for (int code = 0; code < 4; code++) begin
            for (int wr = 0; wr < 2; wr++) begin
                int e;
                e = bcyc(code) + (wr ? T_WR : 0);
                issue(ACT, 0, 16 + code, 0);
                repeat (T_RAS - 1) step();
                burst_code = 2'(code);
                issue(wr ? WR : RD, 0, 0, 0);
                for (int j = 1; j <= e + 1; j++) begin
                    chk(wr ? "R7 pre_ok after write" : "R6 pre_ok after read",
                        int'(pre_ok[0]), int'(j >= e));
                    chk("R1 column access allowed again", int'(rdwr_ok[0]), 1);
                    step();
                end
                issue(PRE, 0, 0, 0);
                repeat (T_RC + 2) step();
            end
        end

        // R8 R9 auto-precharge closing point and reactivation
        for (int code = 0; code < 4; code++) begin
            for (int wr = 0; wr < 2; wr++) begin
                int f, ra;
                f  = imax(bcyc(code) + (wr ? T_WR : 0), T_RAS - T_RCD);
                ra = imax(f + T_RP, T_RC - T_RCD);
                issue(ACT, 3, 32 + code, 0);
                repeat (T_RCD - 1) step();
                burst_code = 2'(code);
                issue(wr ? WR : RD, 3, 0, 1);
                for (int j = 1; j <= ra + 1; j++) begin
                    chk(wr ? "R9 open during write ap" : "R8 open during read ap",
                        int'(bank_open[3]), int'(j <= f));
                    chk(wr ? "R9 act_ok after write ap" : "R8 act_ok after read ap",
                        int'(act_ok[3]), int'(j >= ra));
                    chk("R10 no column access while ap", int'(rdwr_ok[3]), 0);
                    step();
                end
            end
        end

        // R10 commands to a bank with a pending auto-precharge
        issue(ACT, 3, 7, 0);
        repeat (T_RCD - 1) step();
        burst_code = 2'd3;
        issue(RD, 3, 0, 1);
        issue(WR, 3, 0, 0);
        chk("R10 write during ap flagged", int'(protocol_error), 1);
        issue(PRE, 3, 0, 0);
        chk("R10 pre during ap flagged", int'(protocol_error), 1);
        chk("R10 bank still open", int'(bank_open[3]), 1);
        repeat (20) step();
        chk("R8 closed after ap", int'(bank_open[3]), 0);

        finish_run();
    end
endmodule